// File: doc/BRIEF.md
# Periodic Reload Down-Counter Timer

This block is a small system tick timer reached through a single-cycle register port. A 24-bit counter steps down toward zero. On the step after it reaches zero it loads a programmable reload value, so it repeats with a fixed period. Each time the counter passes from one to zero, the block sets a sticky wrap flag. If the interrupt enable is set, it also raises a one-cycle interrupt request.

Software chooses the step source with a control bit. With the bit set, the counter steps on every clock. With the bit clear, it steps only on cycles where an external reference enable input is high. Software gets a period of N steps by loading N-1. Clearing the interrupt enable silences the request line, but the counter keeps running.

A read-only calibration word is also on the port. Its value is a build parameter.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control, reload and current-value registers read zero, `irq` is low, and the calibration word reads `CALIB_VALUE`.
- R2: Registers sit at byte offsets 0x0 (control), 0x4 (reload), 0x8 (current value) and 0xC (calibration). Read data appears on `bus_rdata` in the cycle after `bus_rd`. The control fields are: bit 0 run, bit 1 interrupt enable, bit 2 source (1 = every clock, 0 = reference enable) and bit 16 wrap flag. All other control bits read as zero.
- R3: The reload register holds only bits 23:0. Bits 31:24 read as zero whatever was written.
- R4: A write to the calibration word has no effect on its read value.
- R5: While running, the counter decrements on each step. A step taken at zero loads the reload value. The interrupt period is therefore reload+1 steps.
- R6: The interrupt request is a single-cycle pulse. It is high in the cycle after the step that takes the counter from 1 to 0.
- R7: With the interrupt enable clear, no request is raised, but counting and the wrap flag continue. Setting the enable again resumes requests.
- R8: With the source bit at 0, the counter moves only on cycles where `ref_tick_en` is high.
- R9: Any write to the current-value register clears the counter and the wrap flag, whatever data is written.
- R10: The wrap flag is set on each 1-to-0 step. A control read returns the flag and then clears it. If a new wrap arrives in the same cycle as the read, the flag stays set.
- R11: With a reload value of zero, the counter stays at zero and never sets the flag or raises a request.
- R12: With the run bit clear, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ref_tick_en | input | 1 | External reference step enable |
| irq | output | 1 | Single-cycle interrupt request |

## Verification
The hardest case to reach from the ports is the clear-on-read of the wrap flag. The flag must first be set by a real 1-to-0 step. It must then be read with no further wrap that could set it again. To get there, the stimulus lets the counter run with a short reload, stops it through the run bit, and then reads control twice: the first read must show the flag and the second must not. The reference-source path is driven one step at a time, with single-cycle pulses on `ref_tick_en`. It is also driven with an alternating pattern that must stretch the measured interrupt period to twice reload+1.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  // Word indices (byte address bits 3:2); software decodes these.
  localparam int unsigned IDX_CTRL    = 0;
  localparam int unsigned IDX_RELOAD  = 1;
  localparam int unsigned IDX_CURRENT = 2;
  localparam int unsigned IDX_CALIB   = 3;

  // Control field positions, fixed because software decodes them.
  localparam int unsigned BIT_RUN   = 0;
  localparam int unsigned BIT_IRQEN = 1;
  localparam int unsigned BIT_SRC   = 2;
  localparam int unsigned BIT_FLAG  = 16;

  typedef struct packed {
    logic src_core;  // 1: step every clock, 0: step on reference enable
    logic irq_en;    // gate for the request line only
    logic run;       // counter steps only when set
  } ctrl_t;
endpackage

// File: rtl/tick_step_gen.sv
module tick_step_gen #(
  parameter int unsigned REF_SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic src_core,
  input  logic ref_tick_en,
  output logic step
);
  logic ref_q;

  generate
    if (REF_SYNC_STAGES == 0) begin : g_direct
      assign ref_q = ref_tick_en;
    end else begin : g_sync
      logic [REF_SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[REF_SYNC_STAGES-2:0], ref_tick_en};
      end
      assign ref_q = sync_q[REF_SYNC_STAGES-1];
    end
  endgenerate

  always_comb step = run && (src_core || ref_q);
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             clear,
  input  logic [CNT_W-1:0] reload,
  input  logic             irq_en,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic             irq_q;

  always_comb wrap = step && !clear && (count_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= wrap && irq_en;
      if (clear)
        count_q <= '0;
      else if (step)
        count_q <= (count_q == '0) ? reload : count_q - ONE;
    end
  end

  assign count = count_q;
  assign irq   = irq_q;

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && !irq_en) |=> !irq_q);
  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count_q == '0));
  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !clear) |=> $stable(count_q));
  // R5
  decrement_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clear && count_q != '0) |=> (count_q == $past(count_q) - ONE));
  // R11
  reload_load_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clear && count_q == '0) |=> (count_q == $past(reload)));
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CNT_W       = 24,
  parameter logic [31:0] CALIB_VALUE = 32'h0000_0F9F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              wrap,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              clear,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int unsigned IDX_LSB = 2;
  localparam int unsigned IDX_W   = 2;

  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic              wr_ctrl, wr_reload, rd_ctrl;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic              flag_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  always_comb begin
    idx = bus_addr[IDX_LSB +: IDX_W];
    hit = ((bus_addr >> (IDX_LSB + IDX_W)) == '0);
  end

  always_comb begin
    wr_ctrl   = bus_wr && hit && (idx == IDX_W'(IDX_CTRL));
    wr_reload = bus_wr && hit && (idx == IDX_W'(IDX_RELOAD));
    clear     = bus_wr && hit && (idx == IDX_W'(IDX_CURRENT));
    rd_ctrl   = bus_rd && hit && (idx == IDX_W'(IDX_CTRL));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.run      <= bus_wdata[BIT_RUN];
        ctrl_q.irq_en   <= bus_wdata[BIT_IRQEN];
        ctrl_q.src_core <= bus_wdata[BIT_SRC];
      end
      if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  // A new wrap wins over a clearing read in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)                   flag_q <= 1'b0;
    else if (wrap)             flag_q <= 1'b1;
    else if (rd_ctrl || clear) flag_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (idx)
        IDX_W'(IDX_CTRL): begin
          rd_mux[BIT_RUN]   = ctrl_q.run;
          rd_mux[BIT_IRQEN] = ctrl_q.irq_en;
          rd_mux[BIT_SRC]   = ctrl_q.src_core;
          rd_mux[BIT_FLAG]  = flag_q;
        end
        IDX_W'(IDX_RELOAD):  rd_mux[CNT_W-1:0] = reload_q;
        IDX_W'(IDX_CURRENT): rd_mux[CNT_W-1:0] = count;
        default:             rd_mux = DATA_W'(CALIB_VALUE);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign ctrl      = ctrl_q;
  assign reload    = reload_q;
  assign bus_rdata = rdata_q;

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag_q);
  // R10
  flag_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ctrl && !wrap) |=> !flag_q);
  // R9
  flag_write_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clear && !wrap) |=> !flag_q);
  // R4
  calib_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit && idx == IDX_W'(IDX_CALIB)) |=> (bus_rdata == DATA_W'(CALIB_VALUE)));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W          = 4,
  parameter int unsigned DATA_W          = 32,
  parameter int unsigned CNT_W           = 24,
  parameter int unsigned REF_SYNC_STAGES = 0,
  parameter logic [31:0] CALIB_VALUE     = 32'h0000_0F9F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ref_tick_en,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, count;
  logic             clear, wrap, step;

  tick_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CALIB_VALUE(CALIB_VALUE)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .count(count), .wrap(wrap), .ctrl(ctrl),
    .reload(reload), .clear(clear), .bus_rdata(bus_rdata)
  );

  tick_step_gen #(.REF_SYNC_STAGES(REF_SYNC_STAGES)) u_step (
    .clk(clk), .rst(rst), .run(ctrl.run), .src_core(ctrl.src_core),
    .ref_tick_en(ref_tick_en), .step(step)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .clear(clear), .reload(reload),
    .irq_en(ctrl.irq_en), .count(count), .wrap(wrap), .irq(irq)
  );
endmodule

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
  localparam logic [31:0] CALIB = 32'h0000_0F9F;
  localparam int unsigned NVEC = 6;
  // {address, write data, expected read-back}; run bit kept clear.
  localparam logic [67:0] VEC [0:NVEC-1] = '{
    {4'h0, 32'hFFFF_FFFA, 32'h0000_0002},
    {4'h4, 32'hFFFF_FFFF, 32'h00FF_FFFF},
    {4'h4, 32'h0012_3456, 32'h0012_3456},
    {4'hC, 32'hDEAD_BEEF, CALIB},
    {4'h8, 32'h0000_ABCD, 32'h0000_0000},
    {4'h0, 32'h0000_0004, 32'h0000_0004}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic ref_force = 1'b0, ref_toggle = 1'b0, phase = 1'b0;
  logic ref_tick_en, irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(negedge clk) phase <= ~phase;
  assign ref_tick_en = ref_force | (ref_toggle & phase);

  tick_timer u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_tick_en(ref_tick_en), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_irq(int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (irq) hits++; end
  endtask

  task automatic gap(output int g);
    int n = 0;
    while (!irq && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk); g = 1;
    while (!irq && g < 2000) begin @(negedge clk); g++; end
  endtask

  task automatic restart(logic [31:0] rl, logic [31:0] c);
    wr(4'h0, 32'h0); wr(4'h4, rl); wr(4'h8, 32'h0); wr(4'h0, c);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int g, h;
    idle(3); rst = 1'b0; idle(1);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(4'h0, d); chk("R1 ctrl", d, 32'h0);
    rd(4'h4, d); chk("R1 reload", d, 32'h0);
    rd(4'h8, d); chk("R1 current", d, 32'h0);
    rd(4'hC, d); chk("R1 calib", d, CALIB);

    // R2 R3 R4 R9 table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      rd(VEC[i][67:64], d);
      chk($sformatf("R2/R3/R4/R9 vec%0d", i), d, VEC[i][31:0]);
    end

    // R5 period reload+1 on core clock
    restart(32'd3, 32'h7); gap(g); chk("R5 period reload 3", g, 32'd4);
    // R6 single-cycle request
    @(negedge clk); chk("R6 pulse width", {31'b0, irq}, 32'h0);
    wr(4'h4, 32'd9); gap(g); gap(g); chk("R5 period reload 9", g, 32'd10);

    // R7 gate off: no request, counting continues, flag sets
    restart(32'd4, 32'h5); count_irq(40, h); chk("R7 no irq", h, 32'd0);
    rd(4'h0, d); chk("R7 flag still sets", {31'b0, d[16]}, 32'h1);
    wr(4'h0, 32'h7); gap(g); chk("R7 resumed period", g, 32'd5);

    // R10 flag read then cleared; R12 hold when stopped
    restart(32'd3, 32'h5); idle(12); wr(4'h0, 32'h4);
    rd(4'h8, d); idle(10); rd(4'h8, d2); chk("R12 hold", d2, d);
    rd(4'h0, d); chk("R10 flag seen", d, 32'h0001_0004);
    rd(4'h0, d); chk("R10 flag cleared", d, 32'h0000_0004);

    // R9 current write clears flag
    restart(32'd3, 32'h5); idle(12); wr(4'h0, 32'h4);
    wr(4'h8, 32'h0000_0055);
    rd(4'h0, d); chk("R9 flag cleared by write", d, 32'h4);
    rd(4'h8, d); chk("R9 count cleared", d, 32'h0);

    // R8 reference source
    restart(32'd5, 32'h1); idle(10);
    rd(4'h8, d); chk("R8 no step without ref", d, 32'h0);
    @(negedge clk); ref_force = 1'b1; @(negedge clk); ref_force = 1'b0;
    @(negedge clk); ref_force = 1'b1; @(negedge clk); ref_force = 1'b0;
    idle(5); rd(4'h8, d); chk("R8 two ref steps", d, 32'd4);
    wr(4'h0, 32'h3); ref_toggle = 1'b1;
    gap(g); gap(g); chk("R8 period with half-rate ref", g, 32'd12);
    ref_toggle = 1'b0;

    // R11 reload zero
    restart(32'd0, 32'h7); count_irq(50, h); chk("R11 no irq", h, 32'd0);
    rd(4'h8, d); chk("R11 stays zero", d, 32'h0);
    rd(4'h0, d); chk("R11 no flag", d, 32'h7);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule